// File: doc/BRIEF.md
# Split-Section Ripple Binary Counter

A four-stage binary counter built as two sections that run from separate count inputs. The low section is one toggle stage that halves its count input. The high section is a chain of toggle stages that divides by eight. In that chain the first stage follows the high count input, and every later stage follows the stage before it. A stage toggles when its source goes from high to low. All four stage values are brought out directly.

The count inputs and the ripple links are sampled on a system clock `clk_i`. Each stage toggles in the cycle after it sees a falling edge on its source. A carry through the chain therefore moves one stage per clock cycle, so the outputs settle one after another. Combinations decoded from the outputs can glitch for a few cycles and must not drive clocks or strobes.

Routing `cnt_o[0]` back into `cnt_hi_i` outside the block makes a 4-bit counter that divides by 2, 4, 8 and 16. Driving only `cnt_hi_i` uses the chain as a 3-bit counter and leaves stage 0 free. A clear acts only while both of its inputs are high. It zeroes every stage at once, without waiting for a clock edge, and overrides both count inputs.

Top module: `rc_split_counter`

## Requirements
- R1: While `clr_a_i` and `clr_b_i` are both 1, `cnt_o` is 4'b0000 at once, with no clock edge needed, and count-input edges are ignored.
- R2: With only one of `clr_a_i` and `clr_b_i` at 1, counting continues exactly as if both were 0.
- R3: Each falling edge on `cnt_lo_i` toggles `cnt_o[0]` one clock after the low level is sampled. Rising edges change nothing.
- R4: Each falling edge on `cnt_hi_i` advances `cnt_o[3:1]` by one as a 3-bit binary value with `cnt_o[1]` as its LSB. `cnt_o[0]` is left alone.
- R5: Edges on `cnt_lo_i` leave `cnt_o[3:1]` unchanged unless `cnt_o[0]` is routed to `cnt_hi_i`.
- R6: A chain stage toggles one clock after the stage below it falls from 1 to 0. For example, from `cnt_o[3:1]`=3 a falling edge on `cnt_hi_i` gives 2, then 0, then 4 on three consecutive clocks.
- R7: With `cnt_o[0]` routed to `cnt_hi_i`, successive falling edges on `cnt_lo_i` step `cnt_o` through 0 to 15 (`cnt_o[0]` is the LSB) and wrap from 15 to 0.
- R8: The 3-bit section wraps from 7 to 0 and has no terminal-count output.
- R9: The first falling edge on a count input that starts after the clear is released is counted. No extra settling delay is added.
- R10: While `rst_ni` is 0, `cnt_o` is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples count inputs and ripple links |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_lo_i | input | 1 | Count input of the divide-by-two stage (falling edge) |
| cnt_hi_i | input | 1 | Count input of the divide-by-eight chain (falling edge) |
| clr_a_i | input | 1 | Clear input A; clears only together with B |
| clr_b_i | input | 1 | Clear input B; clears only together with A |
| cnt_o | output | 4 | Stage values; bit 0 is the low section, bits 3:1 the chain |

## Verification
The hardest state to reach is the middle of a carry, while it is still moving up the chain. The bench presets the chain to 3 and then gives one falling edge on `cnt_hi_i`. It samples `cnt_o` after each of the next three clock edges and expects the values 2, 0 and 4. The full 4-bit mode exists only once the bench routes `cnt_o[0]` back into `cnt_hi_i` itself. For that mode the bench steps the count all the way round and through the wrap. It also asserts and releases the clear partway through counting, including a release at the same moment a count input falls.

// File: rtl/rc_pkg.sv
package rc_pkg;
  parameter int unsigned RC_HI_STAGES = 3;
  localparam int unsigned RC_WIDTH = RC_HI_STAGES + 1;
endpackage

// File: rtl/rc_fall_det.sv
module rc_fall_det (
  input  logic clk_i,
  input  logic clr_ni,
  input  logic sig_i,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign fall_o = sig_q & ~sig_i;
endmodule

// File: rtl/rc_toggle_stage.sv
module rc_toggle_stage (
  input  logic clk_i,
  input  logic clr_ni,
  input  logic src_i,
  output logic q_o
);
  logic fall;

  rc_fall_det u_det (
    .clk_i  (clk_i),
    .clr_ni (clr_ni),
    .sig_i  (src_i),
    .fall_o (fall)
  );

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni)   q_o <= 1'b0;
    else if (fall) q_o <= ~q_o;
  end
endmodule

// File: rtl/rc_split_counter.sv
module rc_split_counter #(
  parameter int unsigned HI_STAGES = rc_pkg::RC_HI_STAGES,
  localparam int unsigned W = HI_STAGES + 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_lo_i,
  input  logic         cnt_hi_i,
  input  logic         clr_a_i,
  input  logic         clr_b_i,
  output logic [W-1:0] cnt_o
);
  // gated clear: only both inputs high clear; folded into async reset
  logic clr_n;
  assign clr_n = rst_ni & ~(clr_a_i & clr_b_i);

  logic [W-1:0] src;
  assign src[0] = cnt_lo_i;
  assign src[1] = cnt_hi_i;

  for (genvar k = 2; k < W; k++) begin : g_link
    assign src[k] = cnt_o[k-1];
  end

  for (genvar k = 0; k < W; k++) begin : g_stage
    rc_toggle_stage u_stage (
      .clk_i  (clk_i),
      .clr_ni (clr_n),
      .src_i  (src[k]),
      .q_o    (cnt_o[k])
    );
  end
endmodule

// File: rtl/rc_split_counter_chk.sv
module rc_split_counter_chk #(
  parameter int unsigned HI_STAGES = 3,
  localparam int unsigned W = HI_STAGES + 1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cnt_lo_i,
  input logic         cnt_hi_i,
  input logic         clr_a_i,
  input logic         clr_b_i,
  input logic [W-1:0] cnt_o
);
  logic both_clr, live;
  assign both_clr = clr_a_i & clr_b_i;
  assign live     = rst_ni & ~both_clr;

  // R1
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    both_clr |-> (cnt_o == '0));

  // R3
  lo_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && $past(live) && (cnt_o[0] != $past(cnt_o[0])))
      |-> ($past(cnt_lo_i, 2) && !$past(cnt_lo_i)));

  // R2
  lo_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && $past(live) && $past(live, 2) && $past(cnt_lo_i, 2) && !$past(cnt_lo_i))
      |-> (cnt_o[0] != $past(cnt_o[0])));

  // R4
  hi_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && $past(live) && (cnt_o[1] != $past(cnt_o[1])))
      |-> ($past(cnt_hi_i, 2) && !$past(cnt_hi_i)));

  // R4
  hi_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && $past(live) && $past(live, 2) && $past(cnt_hi_i, 2) && !$past(cnt_hi_i))
      |-> (cnt_o[1] != $past(cnt_o[1])));

  for (genvar k = 2; k < W; k++) begin : g_rip
    // R6
    ripple_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live && $past(live) && (cnt_o[k] != $past(cnt_o[k])))
        |-> ($past(cnt_o[k-1], 2) && !$past(cnt_o[k-1])));

    // R6
    ripple_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live && $past(live) && $past(live, 2) && $past(cnt_o[k-1], 2) && !$past(cnt_o[k-1]))
        |-> (cnt_o[k] != $past(cnt_o[k])));
  end
endmodule

bind rc_split_counter rc_split_counter_chk #(.HI_STAGES(HI_STAGES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnt_lo_i (cnt_lo_i),
  .cnt_hi_i (cnt_hi_i),
  .clr_a_i  (clr_a_i),
  .clr_b_i  (clr_b_i),
  .cnt_o    (cnt_o)
);

// File: tb/tb_rc_split_counter.sv
module tb_rc_split_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lo = 1'b0, hi_drv = 1'b0, ca = 1'b0, cb = 1'b0, tie = 1'b0;
  logic       hi;
  logic [3:0] q;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  assign hi = tie ? q[0] : hi_drv;

  rc_split_counter dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .cnt_lo_i (lo),
    .cnt_hi_i (hi),
    .clr_a_i  (ca),
    .clr_b_i  (cb),
    .cnt_o    (q)
  );

  // vector: {lo, hi, clr_a, clr_b, expected q[3:0]}
  localparam int NV = 24;
  localparam logic [7:0] VEC [NV] = '{
    8'b1000_0000, // R3 rising edge ignored
    8'b0000_0001, // R3 fall toggles q0
    8'b1000_0001,
    8'b0000_0000, // R5 chain untouched
    8'b0100_0000,
    8'b0000_0010, // R4
    8'b1100_0010,
    8'b0000_0101,
    8'b0110_0101, // R2 clr_a alone
    8'b0010_0111, // R2
    8'b0101_0111, // R2 clr_b alone
    8'b0001_1001, // R2
    8'b0100_1001,
    8'b0000_1011,
    8'b0100_1011,
    8'b0000_1101,
    8'b0100_1101,
    8'b0000_1111,
    8'b0100_1111,
    8'b0000_0001, // R8 wrap 7->0
    8'b0111_0000, // R1
    8'b0000_0000, // release with simultaneous fall
    8'b0100_0000,
    8'b0000_0010  // R9 first fall after release
  };

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wipe();
    @(negedge clk); ca = 1'b1; cb = 1'b1;
    settle(2);
    @(negedge clk); ca = 1'b0; cb = 1'b0;
    settle(2);
  endtask

  initial begin
    settle(3);
    check(q, 4'b0000, "R10 reset state");
    @(negedge clk); rst_n = 1'b1;
    settle(3);
    check(q, 4'b0000, "R10 after reset release");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {lo, hi_drv, ca, cb} = VEC[i][7:4];
      settle(6);
      check(q, VEC[i][3:0], $sformatf("R2 R3 R4 R5 R8 R9 table vec %0d", i));
    end

    // R1: clear acts between clock edges
    @(negedge clk); {lo, hi_drv, ca, cb} = 4'b0000;
    @(negedge clk); lo = 1'b1; @(negedge clk); lo = 1'b0;
    settle(4);
    @(negedge clk); #1 ca = 1'b1; cb = 1'b1;
    #1;
    check(q, 4'b0000, "R1 async clear before edge");
    @(negedge clk); ca = 1'b0; cb = 1'b0;

    // R6: ripple from chain value 3
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); hi_drv = 1'b1; settle(2);
      @(negedge clk); hi_drv = 1'b0; settle(6);
    end
    check(q, 4'b0110, "R6 preset chain to 3");
    @(negedge clk); hi_drv = 1'b1; settle(2);
    @(negedge clk); hi_drv = 1'b0;
    settle(1); check(q, 4'b0100, "R6 ripple step 1");
    settle(1); check(q, 4'b0000, "R6 ripple step 2");
    settle(1); check(q, 4'b1000, "R6 ripple step 3");

    // R7: q0 routed to chain input, full 4-bit count
    wipe();
    tie = 1'b1;
    for (int i = 1; i <= 17; i++) begin
      @(negedge clk); lo = 1'b1; settle(2);
      @(negedge clk); lo = 1'b0; settle(6);
      check(q, 4'(i % 16), $sformatf("R7 tied count step %0d", i));
    end

    // R10 mid count
    @(negedge clk); rst_n = 1'b0; #1;
    check(q, 4'b0000, "R10 reset mid count");
    @(negedge clk); rst_n = 1'b1; settle(2);
    @(negedge clk); lo = 1'b1; settle(2);
    @(negedge clk); lo = 1'b0; settle(6);
    check(q, 4'b0001, "R9 first fall after reset release");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule